// File: doc/BRIEF.md
# Segmented Serial ADC Sample Reader

This block fetches one 10-bit conversion from a 4- or 8-channel serial analog-to-digital converter. It talks to the converter over an SPI link in mode 1,1, so the serial clock rests high. A request carries a channel number and a flag that selects single-ended or differential input. The request is taken through a ready/valid handshake. The block then lowers chip select and runs 24 serial clocks, grouped as three byte-wide segments. During those clocks it sends a command frame and collects the reply. Once the transfer is over it returns the result with a one-cycle done pulse.

The command frame is built as follows. The first byte is padding ending in a start bit. The second byte starts with the input-mode flag and the three channel bits, and every remaining bit is sent as 0. The reply carries the result in its last ten bits. The bit in front of those ten is the null bit, which must read 0. All earlier reply bits are discarded.

The serial clock half period is a number of system clock cycles, set from an input. It is clamped so that the serial clock never runs slower than a minimum rate set by a parameter. This keeps the conversion inside the converter's hold window.

Top module: `adc_seg_reader`

## Requirements
- R1: While idle, `spi_cs_n` and `spi_sclk` are both high and `req_ready` is high. All three hold these values after reset.
- R2: MOSI carries 24 bits, most significant first. Bits 23..17 are 0 and bit 16 is the start bit (1). Bit 15 is `req_single` (1 selects single-ended). Bits 14..12 are `req_chan[2:0]`. Bits 11..0 are sent as 0.
- R3: MOSI changes only on falling SCLK edges, and MISO is sampled only on rising SCLK edges. `spi_cs_n` is low from the acceptance edge through all 24 rising edges. It rises one half period after the 24th rising edge.
- R4: The half period h equals `div_half` clock cycles, clamped to the range 1..CLK_HZ/(2*MIN_SCLK_HZ), and is latched when the request is accepted. The k-th SCLK transition (odd k falls, even k rises) takes place k*h cycles after the acceptance edge.
- R5: `res_valid` is high for exactly one cycle: the cycle in which `spi_cs_n` has just risen. `res_data` equals the MISO bits taken at rising edges 15 to 24, most significant first.
- R6: `res_frame_err` equals the MISO bit taken at rising edge 14 (the null bit), so it is 1 when that bit is not 0.
- R7: The MISO bits taken at rising edges 1 to 13 have no effect on `res_data` or `res_frame_err`.
- R8: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from acceptance until the done pulse. A request offered while busy has no effect on the transfer in progress.
- R9: `req_ready` rises together with `res_valid`, so a waiting request is accepted on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_chan | input | 3 | Channel number |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| div_half | input | DIV_W | Requested SCLK half period in clock cycles |
| spi_sclk | output | 1 | Serial clock, rests high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Command bits to the converter |
| spi_miso | input | 1 | Reply bits from the converter |
| res_valid | output | 1 | One-cycle done pulse |
| res_data | output | 10 | Conversion result |
| res_frame_err | output | 1 | Null bit read as 1 |

## Verification
A corrupted shift register or edge counter shows up on MOSI. The wrong bit appears within one half period of the faulty falling edge, and the per-cycle compare catches it there. A fault in the half-period timer moves an SCLK edge away from its k*h slot, which is visible at the first edge after the fault. Capture faults appear only at the done pulse, as wrong result bits or a wrong null flag. Two transfers whose ignored reply bits differ but whose result bits match are compared to expose any leak of the ignored bits into the result.

// File: rtl/adc_seg_pkg.sv
package adc_seg_pkg;
  localparam int SEG_W      = 8;
  localparam int SEG_N      = 3;
  localparam int FRAME_W    = SEG_W * SEG_N;
  localparam int EDGE_N     = 2 * FRAME_W;
  localparam int RES_W      = 10;
  localparam int CHAN_W     = 3;
  localparam int NULL_POS   = RES_W;
  localparam int EDGE_CNT_W = $clog2(EDGE_N + 1);

  typedef struct packed {
    logic             err;
    logic [RES_W-1:0] data;
  } sample_t;

  // Start bit closes the first segment; mode flag and channel open the second.
  function automatic logic [FRAME_W-1:0] build_cmd(input logic single,
                                                   input logic [CHAN_W-1:0] chan);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[2*SEG_W] = 1'b1;
    f[2*SEG_W-1] = single;
    f[2*SEG_W-2 -: CHAN_W] = chan;
    return f;
  endfunction

  // Result sits in the low bits of the reply; null bit just above it.
  function automatic sample_t pick_sample(input logic [FRAME_W-1:0] rx);
    sample_t s;
    s.data = rx[RES_W-1:0];
    s.err  = rx[NULL_POS];
    return s;
  endfunction

  function automatic int unsigned clamp_half(input int unsigned want,
                                             input int unsigned max_h);
    if (want == 0) return 1;
    if (want > max_h) return max_h;
    return want;
  endfunction
endpackage

// File: rtl/sclk_timer.sv
module sclk_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  input  logic [W-1:0] half,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= half - W'(1);
    end else if (run) begin
      if (cnt == '0) cnt <= half - W'(1);
      else           cnt <= cnt - W'(1);
    end
  end

  assign tick = run && (cnt == '0);

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half));
endmodule

// File: rtl/seg_shifter.sv
module seg_shifter import adc_seg_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] cmd,
  input  logic               tick,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx,
  output logic               fall_evt,
  output logic               rise_evt,
  output logic               frame_end
);
  localparam logic [EDGE_CNT_W-1:0] LAST_EDGE = EDGE_CNT_W'(EDGE_N);

  logic [FRAME_W-1:0]    tx;
  logic [EDGE_CNT_W-1:0] ecnt;
  logic                  more;

  assign more      = ecnt < LAST_EDGE;
  assign fall_evt  = tick && more && !ecnt[0];
  assign rise_evt  = tick && more && ecnt[0];
  assign frame_end = tick && !more;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk <= 1'b1;
      mosi <= 1'b0;
      tx   <= '0;
      rx   <= '0;
      ecnt <= '0;
    end else if (load) begin
      tx   <= cmd;
      rx   <= '0;
      ecnt <= '0;
      sclk <= 1'b1;
    end else if (fall_evt) begin
      sclk <= 1'b0;
      mosi <= tx[FRAME_W-1];
      tx   <= {tx[FRAME_W-2:0], 1'b0};
      ecnt <= ecnt + 1'b1;
    end else if (rise_evt) begin
      sclk <= 1'b1;
      rx   <= {rx[FRAME_W-2:0], miso};
      ecnt <= ecnt + 1'b1;
    end
  end

  a_r3_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(mosi));
  a_r3_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_evt && !load) |=> $stable(rx));
  a_r3_edge_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= LAST_EDGE);
endmodule

// File: rtl/adc_seg_reader.sv
module adc_seg_reader import adc_seg_pkg::*; #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int MIN_SCLK_HZ = 10_000,
  parameter int DIV_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_chan,
  input  logic              req_single,
  input  logic [DIV_W-1:0]  div_half,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              res_valid,
  output logic [9:0]        res_data,
  output logic              res_frame_err
);
  localparam int MAX_HALF = CLK_HZ / (2 * MIN_SCLK_HZ);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t             state;
  logic [DIV_W-1:0]   half_q, half_eff, timer_half;
  logic               accept, run, tick;
  logic               fall_evt, rise_evt, frame_end;
  logic [FRAME_W-1:0] rx;
  sample_t            smp;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign run        = (state == ST_RUN);
  assign half_eff   = DIV_W'(clamp_half(32'(div_half), MAX_HALF));
  assign timer_half = req_ready ? half_eff : half_q;
  assign smp        = pick_sample(rx);

  sclk_timer #(.W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(run),
    .half(timer_half), .tick(tick)
  );

  seg_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .cmd(build_cmd(req_single, req_chan)), .tick(tick), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx(rx),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .frame_end(frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      spi_cs_n      <= 1'b1;
      half_q        <= DIV_W'(1);
      res_valid     <= 1'b0;
      res_data      <= '0;
      res_frame_err <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_RUN;
          spi_cs_n <= 1'b0;
          half_q   <= half_eff;
        end
        ST_RUN: if (frame_end) begin
          state         <= ST_IDLE;
          spi_cs_n      <= 1'b1;
          res_valid     <= 1'b1;
          res_data      <= smp.data;
          res_frame_err <= smp.err;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_sclk_high_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);
  a_r8_ready_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);
  a_r3_rise_under_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> !spi_cs_n);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r5_done_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(spi_cs_n));
  a_r4_half_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (half_q >= DIV_W'(1) && 32'(half_q) <= MAX_HALF));
endmodule

// File: tb/adc_seg_reader_test.sv
module adc_seg_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int MIN_HZ     = 10_000;
  localparam int DIV_W      = 8;
  localparam int MAXH       = 50;
  localparam int LIMIT      = 150_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_single = 1'b0;
  logic [2:0] req_chan = '0;
  logic [DIV_W-1:0] div_half = 8'd1;
  logic req_ready, spi_sclk, spi_cs_n, spi_mosi, res_valid, res_frame_err;
  logic spi_miso = 1'b0;
  logic [9:0] res_data;

  int checks = 0, fails = 0, cyc = 0;

  adc_seg_reader #(.CLK_HZ(CLK_HZ), .MIN_SCLK_HZ(MIN_HZ), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_single(req_single), .div_half(div_half),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .res_valid(res_valid), .res_data(res_data),
    .res_frame_err(res_frame_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Converter stand-in: shifts its reply pattern out after each falling SCLK.
  logic [23:0] pat = '0;
  int sk = 0;
  always @(negedge spi_cs_n) sk = 0;
  always @(negedge spi_sclk) if (!spi_cs_n && sk < 24) begin
    spi_miso = pat[23-sk];
    sk++;
  end

  // Behavioural reference: time since acceptance, latched half period.
  bit m_busy = 0;
  int m_t = 0, m_h = 1;
  logic [23:0] m_cmd, m_pat;
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!m_busy || m_t == 49*m_h) begin
        if (req_valid) begin
          m_busy = 1; m_t = 0;
          m_h = (div_half == 0) ? 1 : ((int'(div_half) > MAXH) ? MAXH : int'(div_half));
          m_cmd = {7'b0, 1'b1, req_single, req_chan, 12'b0};
          m_pat = pat;
        end else m_busy = 0;
      end else m_t++;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (m_busy && m_t < 49*m_h) begin
      int n;
      n = m_t / m_h;
      chk(spi_cs_n == 1'b0, "R3 cs held low", spi_cs_n, 0);
      chk(spi_sclk == ((n % 2 == 1) ? 1'b0 : 1'b1), "R4 sclk edge timing", spi_sclk, (n % 2 == 1) ? 0 : 1);
      chk(req_ready == 1'b0, "R8 busy refuses", req_ready, 0);
      chk(res_valid == 1'b0, "R5 no early done", res_valid, 0);
      if (n >= 1) chk(spi_mosi == m_cmd[23-(n-1)/2], "R2 mosi bit", spi_mosi, m_cmd[23-(n-1)/2]);
    end else if (m_busy) begin
      chk(spi_cs_n == 1'b1 && spi_sclk == 1'b1, "R3 release after last rise", {spi_cs_n, spi_sclk}, 3);
      chk(res_valid == 1'b1, "R5 done pulse", res_valid, 1);
      chk(req_ready == 1'b1, "R9 ready with done", req_ready, 1);
      chk(res_data == m_pat[9:0], "R5 result bits", res_data, m_pat[9:0]);
      chk(res_frame_err == m_pat[10], "R6 null bit flag", res_frame_err, m_pat[10]);
    end else begin
      chk(spi_cs_n && spi_sclk && req_ready, "R1 idle lines", {spi_cs_n, spi_sclk, req_ready}, 7);
      chk(res_valid == 1'b0, "R5 no stray done", res_valid, 0);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc >= LIMIT) begin
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
    finish_run();
  end

  task automatic transfer(input bit single, input int chan, input int div, input logic [23:0] p);
    @(negedge clk);
    pat = p; req_single = single; req_chan = 3'(chan); div_half = DIV_W'(div);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
  endtask

  logic [9:0] keep_data;
  logic keep_err;

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n && spi_sclk && req_ready && !res_valid, "R1 reset state",
        {spi_cs_n, spi_sclk, req_ready, res_valid}, 14);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    transfer(1, 5, 2, {13'h1F3A, 1'b0, 10'h2C7});   // R2 single-ended, R5
    transfer(0, 0, 0, {13'h0AAA, 1'b0, 10'h3FF});   // R4 zero clamps to 1
    transfer(1, 7, 200, {13'h1234, 1'b0, 10'h000}); // R4 clamp to maximum
    transfer(0, 3, 3, {13'h0555, 1'b1, 10'h155});   // R6 null bit set
    chk(res_frame_err == 1'b1, "R6 error flagged", res_frame_err, 1);

    transfer(1, 2, 1, {13'h1FFF, 1'b0, 10'h3A1});   // R7 garbage ones
    keep_data = res_data; keep_err = res_frame_err;
    transfer(1, 2, 1, {13'h0000, 1'b0, 10'h3A1});   // R7 garbage zeros
    chk(res_data == keep_data && res_frame_err == keep_err, "R7 ignored bits",
        {res_frame_err, res_data}, {keep_err, keep_data});

    // R8 and R9: offer a second request while busy; it waits until done.
    @(negedge clk);
    pat = {13'h0F0F, 1'b0, 10'h1B6}; req_single = 1'b0; req_chan = 3'd6;
    div_half = 8'd4; req_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    req_chan = 3'd1; req_single = 1'b1; div_half = 8'd9;
    while (!res_valid) @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready at done", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(spi_cs_n == 1'b0, "R9 next request taken at once", spi_cs_n, 0);
    while (!res_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule